// File: doc/BRIEF.md
# MSI Snooping Coherence State Controller

This block tracks the coherence state of every cache line for a group of processors that share one snooping bus. Each line in each processor is Modified, Shared or Invalid. When a request strobe arrives, one processor is the requester. It asks to read or write one line index. In a single clock the block moves the requester's copy of that line to its new state and updates every other processor's copy of the same line. It also reports which bus event the request caused and whether an owner had to write its dirty copy back.

The requester follows one transition table, driven by the read or write it issued. Every other processor follows a second table, driven only by the bus event it snooped. A dirty owner that sees a remote read writes back and keeps a shared copy. A dirty owner that sees a remote read-for-ownership writes back and gives up its copy. An invalid copy never becomes valid through snooping. The complete state array is exposed as a flat vector so that the surrounding logic can read it.

Top module: `msi_snoop_ctrl`

## Requirements
- R1: After reset every line of every processor is Invalid, `bus_evt_o` is 0, `flush_o` is 0 and `flush_cpu_o` is 0.
- R2: A requester read of a line it holds Invalid sets that line to Shared and reports event 1 (bus read). A read of a line held Shared or Modified changes nothing and reports event 0 (none).
- R3: A requester write of a line held Invalid or Shared sets it to Modified and reports event 2 (read-for-ownership). A write of a line already Modified reports event 0.
- R4: A passive processor holding the line Modified that snoops event 1 moves to Shared. The block reports `flush_o`=1, and `flush_cpu_o` gives that processor's index.
- R5: A passive processor holding the line Modified that snoops event 2 moves to Invalid, with `flush_o`=1 and `flush_cpu_o` set to its index.
- R6: A passive processor holding the line Shared stays Shared on event 1 and moves to Invalid on event 2, without a flush.
- R7: A passive processor holding the line Invalid stays Invalid for every snooped event.
- R8: For every line, at most one processor holds it Modified. No processor holds it Shared while another holds it Modified.
- R9: Outputs are registered. They show the result of a request one clock after the edge that accepts it. In a cycle with no accepted request they return to event 0, `flush_o`=0 and `flush_cpu_o`=0.
- R10: A request whose processor index is NUM_CPU or larger is ignored. No state changes, and the outputs read as for an idle cycle.
- R11: A request changes only the addressed line. All other lines keep their states. `state_o` holds the state of processor c, line l at bits [(c*NUM_LINES+l)*2 +: 2], with encoding Invalid=0, Shared=1, Modified=2.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low synchronous reset |
| req_valid_i | input | 1 | Request strobe |
| req_cpu_i | input | CPU_W | Index of the requesting processor |
| req_write_i | input | 1 | 1 = write, 0 = read |
| req_line_i | input | LINE_W | Line index |
| bus_evt_o | output | 2 | Emitted event: 0 none, 1 bus read, 2 read-for-ownership |
| flush_o | output | 1 | A dirty owner wrote back |
| flush_cpu_o | output | CPU_W | Index of the processor that wrote back |
| state_o | output | 2*NUM_CPU*NUM_LINES | Flat view of all line states |

## Verification
A corrupted state entry reaches `state_o` one clock after the faulty request, so the bench compares the whole state vector against its own model after every request. A stale Modified copy may stay hidden until a later request targets that line. It then shows up as a missing or wrong flush, or as a repeated bus event on a hit. For this reason the vector table revisits one line many times, with the role of owner passing between processors. The bench also checks the single-owner invariant on the observed state after every transaction.

// File: rtl/msi_pkg.sv
package msi_pkg;

    typedef enum logic [1:0] {
        ST_INV = 2'd0,
        ST_SHR = 2'd1,
        ST_MOD = 2'd2
    } msi_state_e;

    typedef enum logic [1:0] {
        EV_NONE = 2'd0,
        EV_RD   = 2'd1,
        EV_RDX  = 2'd2
    } bus_evt_e;

endpackage

// File: rtl/msi_req_fsm.sv
module msi_req_fsm
    import msi_pkg::*;
(
    input  msi_state_e cur_i,
    input  logic       write_i,
    output msi_state_e nxt_o,
    output bus_evt_e   evt_o
);
    always_comb begin
        nxt_o = cur_i;
        evt_o = EV_NONE;
        if (write_i) begin
            if (cur_i != ST_MOD) begin
                nxt_o = ST_MOD;
                evt_o = EV_RDX;
            end
        end else if (cur_i == ST_INV) begin
            nxt_o = ST_SHR;
            evt_o = EV_RD;
        end
    end
endmodule

// File: rtl/msi_snoop_fsm.sv
module msi_snoop_fsm
    import msi_pkg::*;
(
    input  msi_state_e cur_i,
    input  bus_evt_e   evt_i,
    output msi_state_e nxt_o,
    output logic       flush_o
);
    always_comb begin
        nxt_o   = cur_i;
        flush_o = 1'b0;
        unique case (evt_i)
            EV_RD: begin
                if (cur_i == ST_MOD) begin
                    nxt_o   = ST_SHR;
                    flush_o = 1'b1;
                end
            end
            EV_RDX: begin
                flush_o = (cur_i == ST_MOD);
                nxt_o   = ST_INV;
            end
            default: ;
        endcase
    end
endmodule

// File: rtl/msi_snoop_ctrl.sv
module msi_snoop_ctrl
    import msi_pkg::*;
#(
    parameter int NUM_CPU   = 3,
    parameter int NUM_LINES = 4,
    localparam int CPU_W    = (NUM_CPU > 1) ? $clog2(NUM_CPU) : 1,
    localparam int LINE_W   = (NUM_LINES > 1) ? $clog2(NUM_LINES) : 1,
    localparam int ST_BITS  = 2 * NUM_CPU * NUM_LINES
) (
    input  logic                clk_i,
    input  logic                rst_ni,
    input  logic                req_valid_i,
    input  logic [CPU_W-1:0]    req_cpu_i,
    input  logic                req_write_i,
    input  logic [LINE_W-1:0]   req_line_i,
    output logic [1:0]          bus_evt_o,
    output logic                flush_o,
    output logic [CPU_W-1:0]    flush_cpu_o,
    output logic [ST_BITS-1:0]  state_o
);
    typedef struct packed {
        msi_state_e [NUM_CPU-1:0][NUM_LINES-1:0] st;
        bus_evt_e                                evt;
        logic                                    flush;
        logic [CPU_W-1:0]                        fcpu;
    } regs_t;

    regs_t d, q;

    msi_state_e [NUM_CPU-1:0] cur_st;
    msi_state_e [NUM_CPU-1:0] snp_nxt;
    logic       [NUM_CPU-1:0] snp_flush;
    msi_state_e               req_cur;
    msi_state_e               req_nxt;
    bus_evt_e                 req_evt;
    logic                     cpu_ok;

    assign cpu_ok = ({1'b0, req_cpu_i} < (CPU_W + 1)'(NUM_CPU));

    for (genvar c = 0; c < NUM_CPU; c++) begin : g_cpu
        assign cur_st[c] = q.st[c][req_line_i];

        msi_snoop_fsm i_snoop (
            .cur_i   (cur_st[c]),
            .evt_i   (req_evt),
            .nxt_o   (snp_nxt[c]),
            .flush_o (snp_flush[c])
        );

        for (genvar l = 0; l < NUM_LINES; l++) begin : g_line
            assign state_o[(c*NUM_LINES+l)*2 +: 2] = q.st[c][l];
        end
    end

    always_comb begin
        req_cur = ST_INV;
        for (int c = 0; c < NUM_CPU; c++) begin
            if (CPU_W'(c) == req_cpu_i) req_cur = cur_st[c];
        end
    end

    msi_req_fsm i_req (
        .cur_i   (req_cur),
        .write_i (req_write_i),
        .nxt_o   (req_nxt),
        .evt_o   (req_evt)
    );

    always_comb begin
        d       = q;
        d.evt   = EV_NONE;
        d.flush = 1'b0;
        d.fcpu  = '0;
        if (req_valid_i && cpu_ok) begin
            d.evt = req_evt;
            for (int c = 0; c < NUM_CPU; c++) begin
                if (CPU_W'(c) == req_cpu_i) begin
                    d.st[c][req_line_i] = req_nxt;
                end else begin
                    d.st[c][req_line_i] = snp_nxt[c];
                    if (snp_flush[c] && !d.flush) begin
                        d.flush = 1'b1;
                        d.fcpu  = CPU_W'(c);
                    end
                end
            end
        end
    end

    always_ff @(posedge clk_i) begin
        if (!rst_ni) begin
            q.st    <= '{default: ST_INV};
            q.evt   <= EV_NONE;
            q.flush <= 1'b0;
            q.fcpu  <= '0;
        end else begin
            q <= d;
        end
    end

    assign bus_evt_o   = q.evt;
    assign flush_o     = q.flush;
    assign flush_cpu_o = q.fcpu;
endmodule

// File: rtl/msi_snoop_ctrl_chk.sv
module msi_snoop_ctrl_chk #(
    parameter int NUM_CPU   = 3,
    parameter int NUM_LINES = 4,
    localparam int CPU_W    = (NUM_CPU > 1) ? $clog2(NUM_CPU) : 1,
    localparam int LINE_W   = (NUM_LINES > 1) ? $clog2(NUM_LINES) : 1,
    localparam int ST_BITS  = 2 * NUM_CPU * NUM_LINES
) (
    input logic                clk_i,
    input logic                rst_ni,
    input logic                req_valid_i,
    input logic [CPU_W-1:0]    req_cpu_i,
    input logic                req_write_i,
    input logic [LINE_W-1:0]   req_line_i,
    input logic [1:0]          bus_evt_o,
    input logic                flush_o,
    input logic [CPU_W-1:0]    flush_cpu_o,
    input logic [ST_BITS-1:0]  state_o
);
    function automatic logic [1:0] pick(logic [ST_BITS-1:0] v, int c, int l);
        return v[(c*NUM_LINES+l)*2 +: 2];
    endfunction

    logic               cpu_ok;
    logic               prv_v;
    logic               prv_wr;
    logic [CPU_W-1:0]   prv_cpu;
    logic [LINE_W-1:0]  prv_line;
    logic [ST_BITS-1:0] prv_st;
    logic               inv_ok;

    assign cpu_ok = ({1'b0, req_cpu_i} < (CPU_W + 1)'(NUM_CPU));

    always_ff @(posedge clk_i) begin
        if (!rst_ni) begin
            prv_v    <= 1'b0;
            prv_wr   <= 1'b0;
            prv_cpu  <= '0;
            prv_line <= '0;
            prv_st   <= '0;
        end else begin
            prv_v    <= req_valid_i && cpu_ok;
            prv_wr   <= req_write_i;
            prv_cpu  <= req_cpu_i;
            prv_line <= req_line_i;
            prv_st   <= state_o;
        end
    end

    always_comb begin
        inv_ok = 1'b1;
        for (int l = 0; l < NUM_LINES; l++) begin
            int nm;
            int ns;
            nm = 0;
            ns = 0;
            for (int c = 0; c < NUM_CPU; c++) begin
                if (pick(state_o, c, l) == 2'd2) nm++;
                if (pick(state_o, c, l) == 2'd1) ns++;
            end
            if (nm > 1 || (nm == 1 && ns != 0)) inv_ok = 1'b0;
        end
    end

    p_read_valid_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
        prv_v && !prv_wr |-> pick(state_o, int'(prv_cpu), int'(prv_line)) != 2'd0);

    p_write_owns_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
        prv_v && prv_wr |-> pick(state_o, int'(prv_cpu), int'(prv_line)) == 2'd2);

    p_flush_has_evt_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
        flush_o |-> bus_evt_o != 2'd0);

    for (genvar c = 0; c < NUM_CPU; c++) begin : g_stick
        p_inv_sticky_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
            prv_v && (prv_cpu != CPU_W'(c)) && pick(prv_st, c, int'(prv_line)) == 2'd0
            |-> pick(state_o, c, int'(prv_line)) == 2'd0);
    end

    p_single_owner_r8: assert property (@(posedge clk_i) disable iff (!rst_ni) inv_ok);

    p_idle_quiet_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !req_valid_i |=> bus_evt_o == 2'd0 && !flush_o && flush_cpu_o == '0);

    p_bad_cpu_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
        req_valid_i && !cpu_ok |=> $stable(state_o) && bus_evt_o == 2'd0);
endmodule

bind msi_snoop_ctrl msi_snoop_ctrl_chk #(
    .NUM_CPU   (NUM_CPU),
    .NUM_LINES (NUM_LINES)
) i_chk (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .req_valid_i (req_valid_i),
    .req_cpu_i   (req_cpu_i),
    .req_write_i (req_write_i),
    .req_line_i  (req_line_i),
    .bus_evt_o   (bus_evt_o),
    .flush_o     (flush_o),
    .flush_cpu_o (flush_cpu_o),
    .state_o     (state_o)
);

// File: tb/test_msi_snoop_ctrl.sv
module test_msi_snoop_ctrl;
    localparam int NC = 3;
    localparam int NL = 4;
    localparam int NV = 14;

    logic        clk_i = 1'b0;
    logic        rst_ni = 1'b0;
    logic        req_valid_i = 1'b0;
    logic [1:0]  req_cpu_i = '0;
    logic        req_write_i = 1'b0;
    logic [1:0]  req_line_i = '0;
    logic [1:0]  bus_evt_o;
    logic        flush_o;
    logic [1:0]  flush_cpu_o;
    logic [23:0] state_o;

    int nvec = 0;
    int nmis = 0;
    logic [1:0] mdl [NC][NL];

    always #4 clk_i = ~clk_i;

    msi_snoop_ctrl #(.NUM_CPU(NC), .NUM_LINES(NL)) i_msi_snoop_ctrl (
        .clk_i, .rst_ni, .req_valid_i, .req_cpu_i, .req_write_i,
        .req_line_i, .bus_evt_o, .flush_o, .flush_cpu_o, .state_o
    );

    // {cpu[9:8], write[7], line[6:5], evt[4:3], flush[2], fcpu[1:0]}
    localparam logic [9:0] VEC [NV] = '{
        {2'd0, 1'b0, 2'd0, 2'd1, 1'b0, 2'd0}, // R2 read miss
        {2'd1, 1'b0, 2'd0, 2'd1, 1'b0, 2'd0}, // R6 sharer keeps S
        {2'd0, 1'b0, 2'd0, 2'd0, 1'b0, 2'd0}, // R2 read hit S
        {2'd2, 1'b1, 2'd0, 2'd2, 1'b0, 2'd0}, // R3/R6 write, sharers drop
        {2'd2, 1'b1, 2'd0, 2'd0, 1'b0, 2'd0}, // R3 write hit M
        {2'd2, 1'b0, 2'd0, 2'd0, 1'b0, 2'd0}, // R2 read hit M
        {2'd0, 1'b0, 2'd0, 2'd1, 1'b1, 2'd2}, // R4 owner flush -> S, R7 cpu1
        {2'd1, 1'b1, 2'd0, 2'd2, 1'b0, 2'd0}, // R3 write from I
        {2'd0, 1'b1, 2'd0, 2'd2, 1'b1, 2'd1}, // R5 owner flush -> I
        {2'd1, 1'b0, 2'd1, 2'd1, 1'b0, 2'd0}, // R11 other line
        {2'd2, 1'b0, 2'd0, 2'd1, 1'b1, 2'd0}, // R4 and R7 third party
        {2'd0, 1'b1, 2'd0, 2'd2, 1'b0, 2'd0}, // R3 upgrade S->M
        {2'd2, 1'b1, 2'd1, 2'd2, 1'b0, 2'd0}, // R6 S on RDX -> I
        {2'd0, 1'b0, 2'd3, 2'd1, 1'b0, 2'd0}  // R11 last line
    };

    function automatic logic [23:0] pack_mdl();
        logic [23:0] v;
        for (int c = 0; c < NC; c++)
            for (int l = 0; l < NL; l++)
                v[(c*NL+l)*2 +: 2] = mdl[c][l];
        return v;
    endfunction

    task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
        nvec++;
        if (act !== exp) begin
            nmis++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic mdl_apply(int cpu, bit wr, int line);
        logic [1:0] e;
        e = 2'd0;
        if (wr) begin
            if (mdl[cpu][line] != 2'd2) e = 2'd2;
            mdl[cpu][line] = 2'd2;
        end else if (mdl[cpu][line] == 2'd0) begin
            e = 2'd1;
            mdl[cpu][line] = 2'd1;
        end
        for (int c = 0; c < NC; c++) begin
            if (c != cpu) begin
                if (e == 2'd1 && mdl[c][line] == 2'd2) mdl[c][line] = 2'd1;
                if (e == 2'd2) mdl[c][line] = 2'd0;
            end
        end
    endtask

    task automatic check_inv();
        bit ok;
        ok = 1'b1;
        for (int l = 0; l < NL; l++) begin
            int nm;
            int ns;
            nm = 0;
            ns = 0;
            for (int c = 0; c < NC; c++) begin
                if (state_o[(c*NL+l)*2 +: 2] == 2'd2) nm++;
                if (state_o[(c*NL+l)*2 +: 2] == 2'd1) ns++;
            end
            if (nm > 1 || (nm == 1 && ns != 0)) ok = 1'b0;
        end
        chk("R8 invariant", 32'(ok), 32'd1);
    endtask

    task automatic issue(int cpu, bit wr, int line);
        @(negedge clk_i);
        req_valid_i = 1'b1;
        req_cpu_i   = 2'(cpu);
        req_write_i = wr;
        req_line_i  = 2'(line);
        @(negedge clk_i);
        req_valid_i = 1'b0;
    endtask

    initial begin
        #(8 * 200000);
        nmis++;
        $display("FAIL watchdog actual=running expected=done");
        $display("== %0d vectors applied, %0d miscompares ==", nvec, nmis);
        $finish;
    end

    initial begin
        for (int c = 0; c < NC; c++)
            for (int l = 0; l < NL; l++)
                mdl[c][l] = 2'd0;
        repeat (3) @(negedge clk_i);
        rst_ni = 1'b1;
        @(negedge clk_i);
        chk("R1 states", 32'(state_o), 32'd0);
        chk("R1 evt", 32'(bus_evt_o), 32'd0);
        chk("R1 flush", {30'd0, flush_o, 1'b0} | 32'(flush_cpu_o), 32'd0);

        for (int i = 0; i < NV; i++) begin
            issue(int'(VEC[i][9:8]), VEC[i][7], int'(VEC[i][6:5]));
            mdl_apply(int'(VEC[i][9:8]), VEC[i][7], int'(VEC[i][6:5]));
            chk("R2/R3 evt", 32'(bus_evt_o), 32'(VEC[i][4:3]));
            chk("R4/R5 flush", 32'(flush_o), 32'(VEC[i][2]));
            chk("R4/R5 fcpu", 32'(flush_cpu_o), 32'(VEC[i][1:0]));
            chk("R6/R7/R11 state", 32'(state_o), 32'(pack_mdl()));
            check_inv();
        end

        // R9: a cycle after a flushing request, outputs fall idle
        issue(1, 1'b0, 0);
        mdl_apply(1, 1'b0, 0);
        chk("R9 flush shown", 32'(flush_o), 32'd1);
        @(negedge clk_i);
        chk("R9 idle evt", 32'(bus_evt_o), 32'd0);
        chk("R9 idle flush", 32'(flush_o), 32'd0);
        chk("R9 idle fcpu", 32'(flush_cpu_o), 32'd0);
        chk("R9 idle state", 32'(state_o), 32'(pack_mdl()));

        // R10: out-of-range requester ignored
        issue(3, 1'b1, 0);
        chk("R10 evt", 32'(bus_evt_o), 32'd0);
        chk("R10 flush", 32'(flush_o), 32'd0);
        chk("R10 state", 32'(state_o), 32'(pack_mdl()));

        // R1: reset in mid-run clears everything
        @(negedge clk_i);
        rst_ni = 1'b0;
        @(negedge clk_i);
        rst_ni = 1'b1;
        chk("R1 re-reset", 32'(state_o), 32'd0);

        $display("== %0d vectors applied, %0d miscompares ==", nvec, nmis);
        $finish;
    end
endmodule